// File: doc/BRIEF.md
# Prioritized Processor Interrupt Level Mapper

This block merges two local interrupt request lines and seven backplane interrupt request levels into the single 3-bit priority level a 68k-style processor samples. Each local line carries its own programmable level, enable, live status and acknowledge mode, vectored or autovectored. A backplane request on level N always raises processor level N, gated by its own enable. The level shown to the processor is the highest level among all enabled, asserted sources. It follows the inputs combinationally and is never latched, so a request stays visible until the requesting device drops it.

When the processor runs an interrupt-acknowledge cycle (address strobe low, function code 3'b111, acknowledged level on address bits 3..1), the block picks the responder among the sources active on that level. The fixed order is: any autovectored local source, then vectored local source 1, then vectored local source 0, then the backplane. It then drives exactly one response: an autovector strobe, an acknowledge strobe to the chosen local device, or a request for a backplane acknowledge cycle at that level. A small four-register port holds the configuration.

Top module: `cpu_irq_router`

## Requirements
- R1: After reset, every register reads 0, `ipl` is 0, `avecN` and both `locAckN` bits are 1, and `bpAckReq` is 0.
- R2: Register 0 bits 1..0 are the enables of local sources 1 and 0. Register 1 holds source 0 level in bits 2..0 and its autovector select in bit 3, and source 1 level in bits 6..4 and its autovector select in bit 7. Register 2 bit N (N = 1..7) enables backplane level N, and bit 0 always reads 0. Register 3 is read-only and ignores writes. Written values take effect from the next clock edge.
- R3: Register 3 bits 1..0 read 1 exactly while `locReqN` bits 1..0 are low, whether or not the source is enabled. Bits 7..2 read 0.
- R4: `ipl` equals the highest level among the active sources. A local source is active when it is enabled, its input is low and its programmed level is nonzero, and it raises its programmed level. Backplane level N is active when it is enabled and `bpIrqN[N]` is low, and it raises level N. With no active source, `ipl` is 0.
- R5: A disabled source, local or backplane, has no effect on `ipl` or on acknowledge selection.
- R6: An acknowledge cycle is recognised only while `asN` is 0 and `fc` is 3'b111. The response appears after the first clock edge that sees it, stays unchanged while the cycle lasts, and clears after the first edge that sees `asN` high. Other `fc` values produce no response.
- R7: If any active local source at the acknowledged level selects autovector mode, `avecN` goes low.
- R8: Otherwise, a vectored active local source at that level gets its `locAckN` bit driven low, with source 1 chosen over source 0.
- R9: Otherwise, if backplane level L is active, `bpAckReq` goes high and `bpAckLevel` equals L.
- R10: If no source is active at the acknowledged level, no response output is asserted.
- R11: At most one of the four response outputs is asserted in any cycle.
- R12: The block never clears a request. After an acknowledge ends, `ipl` still reflects every source whose input remains asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register index |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| locReqN | input | 2 | Local interrupt requests, active low, bit 1 = source 1 |
| bpIrqN | input | 7 | Backplane requests, active low, bit N-1 = level N |
| ipl | output | 3 | Encoded processor interrupt level, 0 = none |
| asN | input | 1 | Processor address strobe, active low |
| fc | input | 3 | Processor function code |
| ackAddr | input | 3 | Address bits 3..1: level being acknowledged |
| avecN | output | 1 | Autovector strobe, active low |
| locAckN | output | 2 | Local acknowledge strobes, active low |
| bpAckReq | output | 1 | Request for a backplane acknowledge cycle |
| bpAckLevel | output | 3 | Level for the backplane acknowledge |

## Verification
The assertions check on every cycle that the response outputs are mutually exclusive, that a response only follows a recognised acknowledge cycle and holds steady while that cycle lasts, that `ipl` is never below the level of any active local source, and that `ipl` is zero whenever every enable is clear. Only the bench's scenarios can show the exact arithmetic of the level encoding over all level and enable combinations, the acknowledge ordering between autovectored, vectored-local and backplane sources at a shared level, the register map, and that requests survive an acknowledge.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LOC = 2;
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] REG_LOC_EN  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_LOC_CFG = 2'd1;
  localparam logic [ADDR_W-1:0] REG_BP_EN   = 2'd2;
  localparam logic [ADDR_W-1:0] REG_STATUS  = 2'd3;

  localparam logic [2:0] FC_IACK = 3'b111;

  typedef struct packed {
    logic wrLocEn;
    logic wrLocCfg;
    logic wrBpEn;
  } regStrobe_t;

  typedef struct packed {
    logic avec;
    logic ack1;
    logic ack0;
    logic bpReq;
  } ackResp_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import cpu_irq_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  regStrobe_t                         stb,
  input  logic [ADDR_W-1:0]                  regAddr,
  input  logic [DATA_W-1:0]                  regWdata,
  output logic [DATA_W-1:0]                  regRdata,
  input  logic [NUM_LOC-1:0]                 locReqN,
  input  logic [NUM_LVL:1]                   bpIrqN,
  output logic [LVL_W-1:0]                   ipl,
  output logic [NUM_LOC-1:0]                 locActive,
  output logic [NUM_LOC-1:0][LVL_W-1:0]      locLevel,
  output logic [NUM_LOC-1:0]                 locAuto,
  output logic [NUM_LVL:1]                   bpActive
);
  localparam int CFG_W = LVL_W + 1;

  logic [NUM_LOC-1:0]       locEn;
  logic [DATA_W-1:0]        locCfg;
  logic [NUM_LVL:1]         bpEn;
  logic [NUM_LOC-1:0]       locSeen;
  logic [NUM_LVL:1]         levelReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locEn  <= '0;
      locCfg <= '0;
      bpEn   <= '0;
    end else begin
      if (stb.wrLocEn)  locEn  <= regWdata[NUM_LOC-1:0];
      if (stb.wrLocCfg) locCfg <= regWdata;
      if (stb.wrBpEn)   bpEn   <= regWdata[NUM_LVL:1];
    end
  end

  assign locSeen  = ~locReqN;
  assign bpActive = ~bpIrqN & bpEn;

  for (genvar s = 0; s < NUM_LOC; s++) begin : g_loc
    assign locLevel[s]  = locCfg[s*CFG_W +: LVL_W];
    assign locAuto[s]   = locCfg[s*CFG_W + LVL_W];
    assign locActive[s] = locSeen[s] && locEn[s] && (locLevel[s] != '0);

    // R4: an active local source is never hidden below the presented level
    assert_loc_visible_R4: assert property (@(posedge clk) disable iff (!rstN)
      locActive[s] |-> (ipl >= locLevel[s]));
  end

  for (genvar lv = 1; lv <= NUM_LVL; lv++) begin : g_lvl
    logic [NUM_LOC-1:0] locHere;
    for (genvar s = 0; s < NUM_LOC; s++) begin : g_hit
      assign locHere[s] = locActive[s] && (locLevel[s] == LVL_W'(lv));
    end
    assign levelReq[lv] = bpActive[lv] || (|locHere);
  end

  always_comb begin
    ipl = '0;
    for (int lv = 1; lv <= NUM_LVL; lv++) begin
      if (levelReq[lv]) ipl = LVL_W'(lv);
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_LOC_EN:  regRdata[NUM_LOC-1:0] = locEn;
      REG_LOC_CFG: regRdata = locCfg;
      REG_BP_EN:   regRdata[NUM_LVL:1] = bpEn;
      default:     regRdata[NUM_LOC-1:0] = locSeen;
    endcase
  end

  // R5: with every enable clear, nothing reaches the processor
  assert_quiet_when_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((locEn == '0) && (bpEn == '0)) |-> (ipl == '0));
endmodule

// File: rtl/irq_control.sv
module irq_control
  import cpu_irq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWe,
  input  logic [ADDR_W-1:0]              regAddr,
  output regStrobe_t                     stb,
  input  logic                           asN,
  input  logic [2:0]                     fc,
  input  logic [LVL_W-1:0]               ackAddr,
  input  logic [NUM_LOC-1:0]             locActive,
  input  logic [NUM_LOC-1:0][LVL_W-1:0]  locLevel,
  input  logic [NUM_LOC-1:0]             locAuto,
  input  logic [NUM_LVL:1]               bpActive,
  output ackResp_t                       resp,
  output logic [LVL_W-1:0]               respLevel
);
  logic               iackNow;
  logic               busy;
  logic [NUM_LOC-1:0] hitLoc;
  logic [NUM_LVL:0]   bpFull;
  ackResp_t           choice;

  always_comb begin
    stb          = '0;
    stb.wrLocEn  = regWe && (regAddr == REG_LOC_EN);
    stb.wrLocCfg = regWe && (regAddr == REG_LOC_CFG);
    stb.wrBpEn   = regWe && (regAddr == REG_BP_EN);
  end

  assign iackNow = !asN && (fc == FC_IACK);
  assign bpFull  = {bpActive, 1'b0};

  for (genvar s = 0; s < NUM_LOC; s++) begin : g_hit
    assign hitLoc[s] = locActive[s] && (locLevel[s] == ackAddr);
  end

  always_comb begin
    choice = '0;
    if (|(hitLoc & locAuto))            choice.avec  = 1'b1;
    else if (hitLoc[1])                 choice.ack1  = 1'b1;
    else if (hitLoc[0])                 choice.ack0  = 1'b1;
    else if (bpFull[ackAddr])           choice.bpReq = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resp      <= '0;
      busy      <= 1'b0;
      respLevel <= '0;
    end else if (iackNow) begin
      if (!busy) begin
        resp      <= choice;
        respLevel <= ackAddr;
        busy      <= 1'b1;
      end
    end else begin
      resp <= '0;
      busy <= 1'b0;
    end
  end

  // R11: never more than one responder
  assert_single_response_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(resp));

  // R6: a response only follows a recognised acknowledge cycle
  assert_resp_needs_iack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resp != '0) |-> $past(iackNow));

  // R6: the response is frozen for the rest of the cycle
  assert_resp_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && iackNow) |=> $stable(resp));

  // R9: a backplane request always carries a real level
  assert_bp_level_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    resp.bpReq |-> (respLevel != '0));
endmodule

// File: rtl/cpu_irq_router.sv
module cpu_irq_router
  import cpu_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic [1:0]  locReqN,
  input  logic [6:0]  bpIrqN,
  output logic [2:0]  ipl,
  input  logic        asN,
  input  logic [2:0]  fc,
  input  logic [2:0]  ackAddr,
  output logic        avecN,
  output logic [1:0]  locAckN,
  output logic        bpAckReq,
  output logic [2:0]  bpAckLevel
);
  regStrobe_t                     stb;
  ackResp_t                       resp;
  logic [NUM_LOC-1:0]             locActive;
  logic [NUM_LOC-1:0][LVL_W-1:0]  locLevel;
  logic [NUM_LOC-1:0]             locAuto;
  logic [NUM_LVL:1]               bpActive;

  irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .locReqN(locReqN),
    .bpIrqN(bpIrqN), .ipl(ipl), .locActive(locActive),
    .locLevel(locLevel), .locAuto(locAuto), .bpActive(bpActive)
  );

  irq_control u_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .stb(stb),
    .asN(asN), .fc(fc), .ackAddr(ackAddr), .locActive(locActive),
    .locLevel(locLevel), .locAuto(locAuto), .bpActive(bpActive),
    .resp(resp), .respLevel(bpAckLevel)
  );

  assign avecN    = ~resp.avec;
  assign locAckN  = ~{resp.ack1, resp.ack0};
  assign bpAckReq = resp.bpReq;
endmodule

// File: tb/tb_cpu_irq_router.sv
`timescale 1ns/1ps
module tb_cpu_irq_router;
  logic clk = 0, rstN = 0, regWe = 0, asN = 1;
  logic [1:0] regAddr = 0, locReqN = 2'b11, locAckN;
  logic [7:0] regWdata = 0, regRdata;
  logic [6:0] bpIrqN = 7'h7F;
  logic [2:0] ipl, fc = 0, ackAddr = 0, bpAckLevel;
  logic avecN, bpAckReq;
  int errors = 0, checks = 0;

  // bench-side configuration mirror
  int lvl[2], aut[2], en[2], ass[2];
  logic [7:0] bpEnM = 0, bpAss = 0;

  always #2.5 clk = ~clk;

  cpu_irq_router dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic apply();
    wr(2'd0, 8'(en[1] * 2 + en[0]));
    wr(2'd1, 8'(aut[1] * 128 + lvl[1] * 16 + aut[0] * 8 + lvl[0]));
    wr(2'd2, bpEnM & 8'hFE);
    @(negedge clk);
    locReqN = ~{ass[1][0], ass[0][0]};
    bpIrqN  = ~bpAss[7:1];
    #1;
  endtask

  function automatic int expIpl();
    int m = 0;
    for (int s = 0; s < 2; s++)
      if (en[s] != 0 && ass[s] != 0 && lvl[s] > m) m = lvl[s];
    for (int l = 1; l < 8; l++)
      if (bpEnM[l] && bpAss[l] && l > m) m = l;
    return m;
  endfunction

  function automatic int expResp(int L);
    bit h[2];
    for (int s = 0; s < 2; s++)
      h[s] = en[s] != 0 && ass[s] != 0 && lvl[s] != 0 && lvl[s] == L;
    if ((h[0] && aut[0] != 0) || (h[1] && aut[1] != 0)) return 8;
    if (h[1]) return 4;
    if (h[0]) return 2;
    if (L != 0 && bpEnM[L] && bpAss[L]) return 1;
    return 0;
  endfunction

  function automatic int obsResp();
    return {28'd0, ~avecN, ~locAckN[1], ~locAckN[0], bpAckReq};
  endfunction

  task automatic iack(int L, logic [2:0] f, string req, int exp);
    int e;
    e = expIpl();
    @(negedge clk); asN = 0; fc = f; ackAddr = 3'(L);
    #1 check({req, " before edge"}, obsResp(), 0);
    @(negedge clk);
    check(req, obsResp(), exp);
    if (exp == 1) check("R9 level", int'(bpAckLevel), L);
    @(negedge clk);
    check("R6 held", obsResp(), exp);
    asN = 1; fc = 0;
    @(negedge clk);
    check("R6 cleared", obsResp(), 0);
    check("R12 ipl after ack", int'(ipl), e);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); check("R1 reg", d, 0); end
    check("R1 ipl", ipl, 0);
    check("R1 responses", obsResp(), 0);
    check("R1 locAckN", locAckN, 3);
    // R2 register map
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R2 locEn", d, 8'h03);
    wr(2'd1, 8'hA5); rd(2'd1, d); check("R2 locCfg", d, 8'hA5);
    wr(2'd2, 8'hFF); rd(2'd2, d); check("R2 bpEn bit0", d, 8'hFE);
    wr(2'd3, 8'hFF); rd(2'd3, d); check("R2 status read-only", d, 0);
    wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 0);
    // R3 live status, enables off
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); locReqN = 2'(p); regAddr = 2'd3;
      #1 check("R3 status", regRdata, (~p) & 3);
      check("R5 disabled ipl", ipl, 0);
    end
    // R4/R5 local level sweep
    for (int l1 = 0; l1 < 8; l1++)
      for (int l0 = 0; l0 < 8; l0++)
        for (int e = 0; e < 4; e++) begin
          lvl[1] = l1; lvl[0] = l0; aut = '{0, 0};
          en[1] = e / 2; en[0] = e % 2; ass = '{1, 1};
          bpEnM = 0; bpAss = 0;
          apply();
          check("R4 local ipl", ipl, expIpl());
        end
    // R4 backplane request sweep, all enabled
    en = '{0, 0}; bpEnM = 8'hFE;
    for (int m = 0; m < 128; m++) begin
      bpAss = 8'(m * 2);
      apply();
      check("R4 backplane ipl", ipl, expIpl());
    end
    // R5 backplane enable sweep, all asserted
    bpAss = 8'hFE;
    for (int m = 0; m < 128; m++) begin
      bpEnM = 8'(m * 2);
      apply();
      check("R5 bp enable ipl", ipl, expIpl());
    end
    // R7..R10 acknowledge ordering sweep
    for (int a1 = 0; a1 < 2; a1++)
      for (int a0 = 0; a0 < 2; a0++)
        for (int l1 = 3; l1 <= 5; l1 += 2)
          for (int l0 = 3; l0 <= 5; l0 += 2)
            for (int b = 0; b < 2; b++) begin
              lvl[1] = l1; lvl[0] = l0; aut[1] = a1; aut[0] = a0;
              en = '{1, 1}; ass = '{1, 1};
              bpAss = 8'hFE; bpEnM = (b != 0) ? 8'hFA : 8'h00;
              apply();
              for (int L = 1; L < 8; L++)
                iack(L, 3'b111, "R7 R8 R9 R10 response", expResp(L));
            end
    // R6 other function code ignored
    iack(3, 3'b110, "R6 non-iack fc", 0);
    // R5 disabled local does not answer
    en = '{0, 1}; bpEnM = 0; apply();
    iack(lvl[1], 3'b111, "R5 disabled local", expResp(lvl[1]));
    // R12 request drops only when input drops
    ass = '{0, 0}; apply();
    check("R12 ipl released", ipl, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule